// File: doc/BRIEF.md
# Complementary PWM Carrier Counter Pair

This block is the counting core behind a complementary (three-phase style) PWM generator. Software writes two 16-bit settings over a small register bus: a dead-time value and a half-period value. When the block is enabled and started, it loads two main up/down counters that are offset by the dead time. It also loads an auxiliary counter that swings between the half-period value and the half-period plus the dead time. Downstream compare and pin logic uses the counter values, the direction flags and one-cycle crest and trough pulses.

The counters move only on a prescaler strobe and only while the start bit is set. Before each start, the settings are checked. A half-period that is too small, or too large for the counter width, raises a configuration error and no counting begins. The settings in use are captured when the counters load, so later bus writes take effect at the next restart. A restart means dropping the enable and raising it again.

Top module: `cpwm_carrier`

## Requirements
- R1: After reset, both settings read back 0xFFFF, all counters read 0, both direction flags are 0, crest, trough and bus_err are 0, and cfg_err is 0.
- R2: A bus access with bus_wide=1 is a full 16-bit access. bus_addr=0 selects the dead-time setting and bus_addr=1 selects the half-period setting. A write updates the setting at the clock edge. A read returns the setting on bus_rdata in the cycle after the request, with bus_err=0.
- R3: A write with bus_wide=0 (byte access) leaves the addressed setting unchanged. It raises bus_err for exactly one cycle, the cycle after the request.
- R4: A read with bus_wide=0 returns bus_rdata=0 with bus_err=1 in the cycle after the request.
- R5: While idle, if mode_en=1 and start=1 and the settings are valid, then in the next cycle the outputs are: cnt_a = dead time, cnt_b = 0, cnt_s = half-period + dead time, dir_main=1 (up) and dir_aux=0 (down). No crest or trough pulse is given for the load.
- R6: After n strobes since load, let C be the half-period, D the dead time and p = n mod 2C. Then cnt_b = p when p ≤ C, and 2C−p otherwise. cnt_a = cnt_b + D at all times. dir_main=1 exactly when n=0 or 1 ≤ p ≤ C.
- R7: crest is 1 for one cycle right after the strobe that makes cnt_b equal C. trough is 1 for one cycle right after the strobe that brings cnt_b back to 0. Neither pulse is given in any other cycle.
- R8: With q = n mod (2D+2), the auxiliary counter follows two rules. For q ≤ D: cnt_s = C+D−q and dir_aux=0. Otherwise: cnt_s = C+q−D−1 and dir_aux=1. The strobe on which a down count meets C (or an up count meets C+D) flips the direction and holds the value.
- R9: In a cycle with tick=0, or with start=0, no counter moves and no pulse is given.
- R10: The settings are valid when C ≥ 2D+3 and C+D ≤ 0xFFFF. If a start is attempted with invalid settings, cfg_err rises in the next cycle and nothing loads. cfg_err stays set until mode_en=0 and blocks starting until then. C = 2D+3 is accepted.
- R11: Setting mode_en=0 returns the block to idle with the counter values held. The next enable-and-start reloads the counters from the current settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = dead time, 1 = half-period |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after request |
| bus_err | output | 1 | Error response for byte access |
| mode_en | input | 1 | Complementary mode enable |
| start | input | 1 | Count run bit |
| tick | input | 1 | Prescaler count strobe |
| cnt_a | output | 16 | First main counter (offset by dead time) |
| cnt_b | output | 16 | Second main counter |
| cnt_s | output | 16 | Auxiliary counter |
| dir_main | output | 1 | Main counters counting up |
| dir_aux | output | 1 | Auxiliary counter counting up |
| crest | output | 1 | Main counters reached their top |
| trough | output | 1 | Main counters returned to zero |
| cfg_err | output | 1 | Settings rejected at start |

## Verification
The hardest cases to reach are the turnaround points, where the counters flip direction. Each depends on the particular pair of settings loaded. One is the auxiliary counter's hold step at a zero dead time, where both of its bounds coincide. Another is the exact boundary C = 2D+3. The stimulus sweeps the dead time from 0 to 3 with the half-period at the boundary value and two above it. Each pair runs through several full carrier periods. Strobe gaps and start-low cycles are mixed in, so every turnaround is seen both directly after a strobe and after a hold. The value one below the boundary is tried before each valid pair, so the error path is crossed every time.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_t;

  localparam int unsigned REG_COUNT = 2;

  function automatic logic setting_ok(input logic [15:0] cyc, input logic [15:0] dt);
    logic [17:0] need;
    logic [17:0] peak;
    need = {1'b0, dt, 1'b0} + 18'd3;
    peak = {2'b00, cyc} + {2'b00, dt};
    return ({2'b00, cyc} >= need) && (peak <= 18'h0FFFF);
  endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs #(
  parameter int W = 16,
  parameter int NREG = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic         bus_addr,
  input  logic         bus_wide,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         bus_err,
  output logic [W-1:0] dt_q,
  output logic [W-1:0] cyc_q
);
  localparam logic [W-1:0] RST_VAL = {W{1'b1}};

  logic [W-1:0] regs [NREG];
  logic         wr_ok;
  logic         bad_acc;

  assign wr_ok   = bus_sel && bus_wr && bus_wide;
  assign bad_acc = bus_sel && !bus_wide;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= RST_VAL;
      end else if (wr_ok && (int'(bus_addr) == i)) begin
        regs[i] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= bad_acc;
      bus_rdata <= (bus_sel && !bus_wr && bus_wide) ? regs[bus_addr] : '0;
    end
  end

  assign dt_q  = regs[0];
  assign cyc_q = regs[1];
endmodule

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_en,
  input  logic         start,
  input  logic         tick,
  input  logic [W-1:0] dt_q,
  input  logic [W-1:0] cyc_q,
  output logic         load,
  output logic         step,
  output logic         run_q,
  output logic         cfg_err,
  output logic [W-1:0] dt_run,
  output logic [W-1:0] cyc_run,
  output logic [W-1:0] top_run
);
  import cpwm_pkg::*;

  run_st_t st;
  logic    try_go;
  logic    ok;

  assign ok     = setting_ok(cyc_q, dt_q);
  assign try_go = (st == ST_IDLE) && mode_en && start && !cfg_err;
  assign load   = try_go && ok;
  assign step   = (st == ST_RUN) && mode_en && start && tick;
  assign run_q  = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cfg_err <= 1'b0;
      dt_run  <= '0;
      cyc_run <= '0;
      top_run <= '0;
    end else begin
      if (!mode_en) begin
        st      <= ST_IDLE;
        cfg_err <= 1'b0;
      end else if (load) begin
        st      <= ST_RUN;
        dt_run  <= dt_q;
        cyc_run <= cyc_q;
        top_run <= cyc_q + dt_q;
      end else if (try_go) begin
        cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpwm_main_cnt.sv
module cpwm_main_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dt_q,
  input  logic [W-1:0] cyc_q,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         dir_up,
  output logic         crest,
  output logic         trough
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      dir_up <= 1'b0;
      crest  <= 1'b0;
      trough <= 1'b0;
    end else begin
      crest  <= 1'b0;
      trough <= 1'b0;
      if (load) begin
        cnt_a  <= dt_q;
        cnt_b  <= '0;
        dir_up <= 1'b1;
      end else if (step) begin
        if (dir_up) begin
          if (cnt_b == cyc_q) begin
            dir_up <= 1'b0;
            cnt_a  <= cnt_a - ONE;
            cnt_b  <= cnt_b - ONE;
            trough <= (cnt_b == ONE);
          end else begin
            cnt_a  <= cnt_a + ONE;
            cnt_b  <= cnt_b + ONE;
            crest  <= ((cnt_b + ONE) == cyc_q);
          end
        end else begin
          if (cnt_b == '0) begin
            dir_up <= 1'b1;
            cnt_a  <= cnt_a + ONE;
            cnt_b  <= cnt_b + ONE;
            crest  <= (ONE == cyc_q);
          end else begin
            cnt_a  <= cnt_a - ONE;
            cnt_b  <= cnt_b - ONE;
            trough <= (cnt_b == ONE);
          end
        end
      end
    end
  end
endmodule

// File: rtl/cpwm_aux_cnt.sv
module cpwm_aux_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] cyc_q,
  input  logic [W-1:0] top_q,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_s,
  output logic         dir_up
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_s  <= '0;
      dir_up <= 1'b0;
    end else if (load) begin
      cnt_s  <= load_val;
      dir_up <= 1'b0;
    end else if (step) begin
      if (dir_up) begin
        if (cnt_s == top_q) dir_up <= 1'b0;
        else                cnt_s  <= cnt_s + ONE;
      end else begin
        if (cnt_s == cyc_q) dir_up <= 1'b1;
        else                cnt_s  <= cnt_s - ONE;
      end
    end
  end
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic         bus_addr,
  input  logic         bus_wide,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         bus_err,
  input  logic         mode_en,
  input  logic         start,
  input  logic         tick,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic [W-1:0] cnt_s,
  output logic         dir_main,
  output logic         dir_aux,
  output logic         crest,
  output logic         trough,
  output logic         cfg_err
);
  logic [W-1:0] dt_q, cyc_q;
  logic [W-1:0] dt_run, cyc_run, top_run;
  logic         load, step, run_q;

  cpwm_regs #(.W(W), .NREG(cpwm_pkg::REG_COUNT)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .dt_q(dt_q), .cyc_q(cyc_q)
  );

  cpwm_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_en(mode_en), .start(start), .tick(tick),
    .dt_q(dt_q), .cyc_q(cyc_q), .load(load), .step(step), .run_q(run_q),
    .cfg_err(cfg_err), .dt_run(dt_run), .cyc_run(cyc_run), .top_run(top_run)
  );

  cpwm_main_cnt #(.W(W)) u_main (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .dt_q(dt_q), .cyc_q(cyc_run),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .dir_up(dir_main),
    .crest(crest), .trough(trough)
  );

  cpwm_aux_cnt #(.W(W)) u_aux (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .cyc_q(cyc_run), .top_q(top_run), .load_val(cyc_q + dt_q),
    .cnt_s(cnt_s), .dir_up(dir_aux)
  );
endmodule

// File: rtl/cpwm_carrier_chk.sv
module cpwm_carrier_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic         bus_wide,
  input logic [W-1:0] bus_rdata,
  input logic         bus_err,
  input logic         mode_en,
  input logic         start,
  input logic         tick,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] cnt_b,
  input logic [W-1:0] cnt_s,
  input logic         crest,
  input logic         trough,
  input logic         cfg_err,
  input logic         run_q,
  input logic [W-1:0] dt_run
);
  AST_BYTE_WR_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && !bus_wide) |=> bus_err); // R3
  AST_BYTE_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !bus_wide) |=> (bus_rdata == '0) && bus_err); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ((cnt_a - cnt_b) == dt_run)); // R6
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(crest && trough)); // R7
  AST_CREST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    crest |=> !crest); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run_q && !(mode_en && start && tick)) |=>
      ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_s) && !crest && !trough)); // R9
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !run_q); // R10
endmodule

bind cpwm_carrier cpwm_carrier_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wide(bus_wide),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .mode_en(mode_en), .start(start),
  .tick(tick), .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_s(cnt_s), .crest(crest),
  .trough(trough), .cfg_err(cfg_err), .run_q(run_q), .dt_run(dt_run)
);

// File: tb/cpwm_carrier_tb.sv
module cpwm_carrier_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr, bus_addr, bus_wide;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic        mode_en, start, tick;
  logic [15:0] cnt_a, cnt_b, cnt_s;
  logic        dir_main, dir_aux, crest, trough, cfg_err;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_carrier u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .mode_en(mode_en), .start(start), .tick(tick),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_s(cnt_s), .dir_main(dir_main),
    .dir_aux(dir_aux), .crest(crest), .trough(trough), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_acc(input logic wr, input logic addr, input logic wide, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wide = wide; bus_wdata = d;
    clk1();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wide = 1'b1;
  endtask

  task automatic check_all(input int n, input int d, input int c, input logic stepped);
    int p, q, eb, es;
    p  = n % (2*c);
    q  = n % (2*d + 2);
    eb = (p <= c) ? p : 2*c - p;
    es = (q <= d) ? c + d - q : c + q - d - 1;
    chk("R6 cnt_b", cnt_b, eb);
    chk("R6 cnt_a", cnt_a, eb + d);
    chk("R6 dir_main", dir_main, (n == 0 || (p >= 1 && p <= c)) ? 1 : 0);
    chk("R7 crest", crest, (stepped && n > 0 && p == c) ? 1 : 0);
    chk("R7 trough", trough, (stepped && n > 0 && p == 0) ? 1 : 0);
    chk("R8 cnt_s", cnt_s, es);
    chk("R8 dir_aux", dir_aux, (q <= d) ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wide = 1; bus_wdata = 0;
    mode_en = 0; start = 0; tick = 0;
    clk1(); clk1();
    rst = 1'b0;
    clk1();
    // R1 reset state
    chk("R1 cnt_a", cnt_a, 0); chk("R1 cnt_b", cnt_b, 0); chk("R1 cnt_s", cnt_s, 0);
    chk("R1 dirs", {dir_main, dir_aux}, 0); chk("R1 pulses", {crest, trough}, 0);
    chk("R1 errs", {bus_err, cfg_err}, 0);
    bus_acc(1'b0, 1'b0, 1'b1, 16'h0);
    chk("R1 dt reset", bus_rdata, 16'hFFFF);
    bus_acc(1'b0, 1'b1, 1'b1, 16'h0);
    chk("R1 cyc reset", bus_rdata, 16'hFFFF);
    // R10 reset values are invalid
    mode_en = 1; start = 1;
    clk1();
    chk("R10 cfg_err reset vals", cfg_err, 1);
    clk1();
    chk("R10 no load", cnt_b + cnt_s, 0);
    mode_en = 0;
    clk1();
    chk("R10 cfg_err cleared", cfg_err, 0);

    // R2 / R3 / R4 bus
    bus_acc(1'b1, 1'b0, 1'b1, 16'h1234);
    chk("R2 wr err", bus_err, 0);
    bus_acc(1'b0, 1'b0, 1'b1, 16'h0);
    chk("R2 rd dt", bus_rdata, 16'h1234); chk("R2 rd err", bus_err, 0);
    bus_acc(1'b1, 1'b1, 1'b1, 16'hBEEF);
    bus_acc(1'b1, 1'b1, 1'b0, 16'h0011);
    chk("R3 byte wr err", bus_err, 1);
    clk1();
    chk("R3 err one cycle", bus_err, 0);
    bus_acc(1'b0, 1'b1, 1'b1, 16'h0);
    chk("R3 cyc unchanged", bus_rdata, 16'hBEEF);
    bus_acc(1'b0, 1'b1, 1'b0, 16'h0);
    chk("R4 byte rd data", bus_rdata, 0); chk("R4 byte rd err", bus_err, 1);
    bus_acc(1'b1, 1'b0, 1'b0, 16'h0003);
    bus_acc(1'b0, 1'b0, 1'b1, 16'h0);
    chk("R3 dt unchanged", bus_rdata, 16'h1234);

    // R10 overflow: C + D above 16 bits rejected
    bus_acc(1'b1, 1'b0, 1'b1, 16'h0010);
    bus_acc(1'b1, 1'b1, 1'b1, 16'hFFF5);
    mode_en = 1; start = 1;
    clk1();
    chk("R10 overflow rejected", cfg_err, 1);
    mode_en = 0; start = 0;
    clk1();

    for (int d = 0; d <= 3; d++) begin
      for (int k = 0; k < 3; k++) begin
        int c, n, cyc_len;
        c = 2*d + 3 + 2*k;
        // R10 one below boundary rejected
        bus_acc(1'b1, 1'b0, 1'b1, 16'(d));
        bus_acc(1'b1, 1'b1, 1'b1, 16'(c - 1 - 2*k));
        mode_en = 1; start = 1;
        clk1();
        chk("R10 below boundary", cfg_err, 1);
        mode_en = 0; start = 0;
        clk1();
        bus_acc(1'b1, 1'b1, 1'b1, 16'(c));
        mode_en = 1; start = 1; tick = 1;
        clk1();
        // R5 load (R11 reload on later configs)
        chk("R5 cfg_err", cfg_err, 0);
        chk("R5 R11 cnt_a", cnt_a, d); chk("R5 cnt_b", cnt_b, 0);
        chk("R5 cnt_s", cnt_s, c + d);
        chk("R5 dir_main", dir_main, 1); chk("R5 dir_aux", dir_aux, 0);
        chk("R5 no pulse", {crest, trough}, 0);
        n = 0;
        cyc_len = 4*c + 5;
        for (int i = 0; i < cyc_len; i++) begin
          if (i % 7 == 3) begin
            tick = 0; clk1(); tick = 1;
            check_all(n, d, c, 1'b0); // R9 tick low
          end else if (i % 11 == 5) begin
            start = 0; clk1(); start = 1;
            check_all(n, d, c, 1'b0); // R9 start low
          end else begin
            clk1();
            n++;
            check_all(n, d, c, 1'b1);
          end
        end
        // R11 disable holds counters
        mode_en = 0; tick = 1;
        clk1(); clk1();
        check_all(n, d, c, 1'b0);
        chk("R11 cfg_err", cfg_err, 0);
        tick = 0; start = 0;
        clk1();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule